// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block drives the column side of one burst on a two-bank SDRAM with 9-bit column addresses. A mode word sets three things: the CAS latency, the beat ordering and the burst length. The block holds that setting until a new, legal word replaces it. A column command gives a start column, a bank and a direction. From that command the block produces one beat per cycle. Each beat carries its column address. Write beats carry a write-enable that follows the data mask in the same cycle. Read beats produce a data-valid strobe a CAS latency later, together with an output enable that the data mask cancels two cycles after the mask was sampled.

A burst ends in one of four ways: it reaches its length, a burst-stop arrives, a new column command arrives, or a precharge arrives. Full-page mode wraps around the whole 512-column page and runs until one of the last three events. The block has no data path and no back-pressure. Each beat is fixed to its cycle, so every interface is a plain strobe and no valid/ready handshake applies.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset the setting is CAS latency 2, sequential order, burst length 4, and no beat, read strobe or error is active.
- R2: A mode word is legal when four conditions hold: bits above 6 are zero, bits [6:4] are 1, 2 or 3 (the CAS latency), bits [2:0] are 0..3 (length 1, 2, 4, 8), and code 7 (full page) appears only with bit [3] clear. Any other word raises `mode_err` for one cycle, in the cycle after the write, and leaves the setting unchanged.
- R3: With bit [3] = 0 (sequential), beat i uses the start column with its low log2(length) bits replaced by (start + i) mod length.
- R4: With bit [3] = 1 (interleave), beat i uses the start column XOR i.
- R5: In full-page mode, beat i uses (start + i) mod 512, and the burst continues until a stop, a column command or a precharge.
- R6: A burst that is not interrupted issues exactly length beats in consecutive cycles, the first of them in the command cycle.
- R7: For a read beat in cycle t, `rd_valid` is high in cycle t + CAS latency.
- R8: DQM high in cycle t clears `rd_oe` in cycle t + 2 and does not affect `rd_valid`.
- R9: A write beat raises `wr_en` in its own cycle unless DQM is high in that cycle.
- R10: A burst-stop prevents any beat in its own cycle and in later cycles. Read data already issued still arrives.
- R11: A column command during a burst ends that burst and starts a new one from the new column, bank and direction.
- R12: A precharge lets the beat of its own cycle issue, with `wr_en` forced low for a write. At CAS latency 1 or 2 that beat's read data still arrives. At latency 3 it is dropped. No beats follow the precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode-word write strobe |
| mode_word | input | 12 | Mode word |
| mode_err | output | 1 | Rejected mode word, one cycle |
| cmd_valid | input | 1 | Column command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_bank | input | 1 | Bank of the command |
| cmd_col | input | 9 | Start column |
| stop | input | 1 | Burst-stop |
| precharge | input | 1 | Precharge of the bursting bank |
| dqm | input | 1 | Data mask |
| beat_valid | output | 1 | A beat is issued this cycle |
| beat_write | output | 1 | Direction of the current beat |
| beat_bank | output | 1 | Bank of the current beat |
| beat_col | output | 9 | Column of the current beat |
| wr_en | output | 1 | Write data is taken this cycle |
| rd_valid | output | 1 | Read data is due this cycle |
| rd_oe | output | 1 | Read output enable after masking |

## Verification
The assertions rely on three input rules. At most one of column command, stop and precharge is high in a cycle. A mode word is written only while no burst or read data is in flight. A column command does not follow a latency-3 precharge by less than one cycle. The stimulus meets these rules by running each scenario from an idle sequencer and draining the pipeline before the next mode write. It also issues stops, precharges and interrupting commands only in cycles that carry no other command.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;
  typedef struct packed {
    logic [1:0] cl;
    logic       il;
    logic       full;
    logic [1:0] len_log;
  } sdseq_mode_t;

  localparam sdseq_mode_t SDSEQ_RESET_MODE = '{cl: 2'd2, il: 1'b0, full: 1'b0, len_log: 2'd2};
endpackage

// File: rtl/sdseq_mode.sv
module sdseq_mode
  import sdseq_pkg::*;
#(
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [MODE_W-1:0] word,
  output sdseq_mode_t       mode,
  output logic              err
);
  localparam int HI_W = MODE_W - 7;

  logic [2:0] len_code;
  logic [2:0] cl_code;
  logic       legal;

  assign len_code = word[2:0];
  assign cl_code  = word[6:4];

  always_comb begin
    legal = (word[MODE_W-1:7] == HI_W'(0));
    if (cl_code == 3'd0 || cl_code > 3'd3) legal = 1'b0;
    if (len_code[2] && !(len_code == 3'd7 && !word[3])) legal = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= SDSEQ_RESET_MODE;
      err  <= 1'b0;
    end else begin
      err <= wr && !legal;
      if (wr && legal) begin
        mode.cl      <= cl_code[1:0];
        mode.il      <= word[3];
        mode.full    <= (len_code == 3'd7);
        mode.len_log <= len_code[1:0];
      end
    end
  end

  AST_BAD_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !legal) |=> (mode == $past(mode))); // R2
  AST_CL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode.cl != 2'd0); // R1
endmodule

// File: rtl/sdseq_order.sv
module sdseq_order
  import sdseq_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  sdseq_mode_t      mode,
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] col,
  output logic             last
);
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] sum;

  assign mask = (COL_W'(1) << mode.len_log) - COL_W'(1);
  assign sum  = start + idx;

  always_comb begin
    if (mode.full)    col = sum;
    else if (mode.il) col = start ^ (idx & mask);
    else              col = (start & ~mask) | (sum & mask);
    last = !mode.full && (idx == mask);
  end
endmodule

// File: rtl/sdseq_rdpipe.sv
module sdseq_rdpipe #(
  parameter int MAX_CL = 3,
  parameter int DQM_LAT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat_in,
  input  logic       dqm,
  input  logic [1:0] cl,
  output logic       rd_valid,
  output logic       rd_oe
);
  logic [MAX_CL-1:0]  sh;
  logic [DQM_LAT-1:0] mk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0;
      mk <= '0;
    end else begin
      sh <= {sh[MAX_CL-2:0], beat_in};
      mk <= {mk[DQM_LAT-2:0], dqm};
    end
  end

  assign rd_valid = sh[cl - 2'd1];
  assign rd_oe    = rd_valid && !mk[DQM_LAT-1];

  AST_RD_LAT1: assert property (@(posedge clk) disable iff (!rst_n)
    (cl == 2'd1 && beat_in) |=> rd_valid); // R7
  AST_RD_LAT2: assert property (@(posedge clk) disable iff (!rst_n)
    (cl == 2'd2 && $past(beat_in)) |=> rd_valid); // R7
  AST_MASK_OE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dqm) && rd_valid) |=> !rd_oe || !$past(rd_valid)); // R8
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdseq_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MODE_W = 12,
  parameter int MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_word,
  output logic              mode_err,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic              cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              stop,
  input  logic              precharge,
  input  logic              dqm,
  output logic              beat_valid,
  output logic              beat_write,
  output logic              beat_bank,
  output logic [COL_W-1:0]  beat_col,
  output logic              wr_en,
  output logic              rd_valid,
  output logic              rd_oe
);
  sdseq_mode_t      md;
  logic             act_q, wr_q, bank_q;
  logic [COL_W-1:0] start_q, idx_q;
  logic [COL_W-1:0] cur_start, cur_idx;
  logic             last, rd_beat;

  sdseq_mode #(.MODE_W(MODE_W)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr(mode_wr), .word(mode_word), .mode(md), .err(mode_err)
  );

  assign beat_valid = cmd_valid || (act_q && !stop);
  assign cur_start  = cmd_valid ? cmd_col : start_q;
  assign cur_idx    = cmd_valid ? '0 : idx_q;
  assign beat_write = cmd_valid ? cmd_write : wr_q;
  assign beat_bank  = cmd_valid ? cmd_bank : bank_q;

  sdseq_order #(.COL_W(COL_W)) u_order (
    .mode(md), .start(cur_start), .idx(cur_idx), .col(beat_col), .last(last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      bank_q  <= 1'b0;
      start_q <= '0;
      idx_q   <= '0;
    end else begin
      act_q   <= beat_valid && !last && !precharge;
      wr_q    <= beat_write;
      bank_q  <= beat_bank;
      start_q <= cur_start;
      idx_q   <= cur_idx + COL_W'(1);
    end
  end

  assign wr_en   = beat_valid && beat_write && !dqm && !precharge;
  assign rd_beat = beat_valid && !beat_write && !(precharge && md.cl == 2'd3);

  sdseq_rdpipe #(.MAX_CL(MAX_CL), .DQM_LAT(2)) u_rdpipe (
    .clk(clk), .rst_n(rst_n), .beat_in(rd_beat), .dqm(dqm), .cl(md.cl),
    .rd_valid(rd_valid), .rd_oe(rd_oe)
  );

  AST_ONE_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, stop, precharge})); // R10
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!beat_valid || cmd_valid)); // R10
  AST_PRE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    precharge |=> (!beat_valid || cmd_valid)); // R12
  AST_IDX_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !md.full) |-> ((idx_q >> md.len_log) == '0)); // R6
  AST_PRE_CUT_CL3: assert property (@(posedge clk) disable iff (!rst_n)
    (precharge && md.cl == 2'd3 && !beat_write) |=> ##2 !rd_valid); // R12
  AST_WR_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (beat_valid && !dqm)); // R9
endmodule

// File: tb/test_sdram_burst_seq.sv
module test_sdram_burst_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [11:0] mode_word = '0;
  logic mode_err;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, cmd_bank = 1'b0;
  logic [8:0] cmd_col = '0;
  logic stop = 1'b0, precharge = 1'b0, dqm = 1'b0;
  logic beat_valid, beat_write, beat_bank, wr_en, rd_valid, rd_oe;
  logic [8:0] beat_col;

  sdram_burst_seq i_sdram_burst_seq (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_word(mode_word), .mode_err(mode_err),
    .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .stop(stop), .precharge(precharge), .dqm(dqm),
    .beat_valid(beat_valid), .beat_write(beat_write), .beat_bank(beat_bank), .beat_col(beat_col),
    .wr_en(wr_en), .rd_valid(rd_valid), .rd_oe(rd_oe)
  );

  always #10 clk = ~clk;

  typedef struct { int cyc; logic [8:0] col; bit wr; bit bank; bit we; int req; } beat_t;
  typedef struct { int cyc; bit oe; int req; } rdx_t;
  beat_t beat_q[$];
  rdx_t  rd_q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit dqm_plan [0:4095];
  bit done = 0;
  int m_bl = 4, m_cl = 2; bit m_il = 0, m_full = 0;

  always @(posedge clk) cyc <= cyc + 1;
  initial forever begin @(posedge clk); #2 dqm = dqm_plan[cyc]; end

  task automatic step(); @(posedge clk); #2; endtask

  function automatic logic [8:0] exp_col(logic [8:0] s, int i);
    logic [8:0] mk, sm;
    mk = 9'(m_bl - 1); sm = s + 9'(i);
    if (m_full) return sm;
    if (m_il) return s ^ 9'(i);
    return (s & ~mk) | (sm & mk);
  endfunction

  task automatic fail_chk(string rq, string what, int act, int expv);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", rq, what, act, expv, cyc);
  endtask

  // driver: issue a column command, expect nb beats; pre_last: precharge lands on final beat
  task automatic col_cmd(bit wr, logic [8:0] col, bit bank, int nb, bit pre_last, int req);
    int c;
    c = cyc;
    cmd_valid = 1; cmd_write = wr; cmd_col = col; cmd_bank = bank;
    for (int i = 0; i < nb; i++) begin
      bit pl;
      pl = pre_last && (i == nb - 1);
      beat_q.push_back('{c + i, exp_col(col, i), wr, bank, wr && !dqm_plan[c + i] && !pl, req});
      if (!wr && !(pl && m_cl == 3))
        rd_q.push_back('{c + i + m_cl, !dqm_plan[c + i + m_cl - 2], req});
    end
    step();
    cmd_valid = 0;
  endtask

  task automatic set_mode(logic [11:0] w, int req);
    bit ok;
    ok = (w[11:7] == 0) && (w[6:4] >= 1 && w[6:4] <= 3) && (w[2:0] <= 3 || (w[2:0] == 7 && !w[3]));
    mode_wr = 1; mode_word = w;
    step();
    mode_wr = 0;
    @(negedge clk);
    checks++;
    if (mode_err !== !ok) fail_chk(req == 2 ? "R2" : "R1", "mode_err", mode_err, !ok);
    if (ok) begin
      m_cl = w[6:4]; m_il = w[3]; m_full = (w[2:0] == 7);
      m_bl = m_full ? 512 : (1 << w[1:0]);
    end
    step();
  endtask

  // monitor: pop and compare
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      while (beat_q.size() > 0 && beat_q[0].cyc < cyc) begin
        checks++; fail_chk($sformatf("R%0d", beat_q[0].req), "missing beat", 0, 1);
        void'(beat_q.pop_front());
      end
      if (beat_valid) begin
        checks++;
        if (beat_q.size() == 0 || beat_q[0].cyc != cyc) fail_chk("R6", "unexpected beat", beat_col, 0);
        else begin
          beat_t e;
          e = beat_q.pop_front();
          if (beat_col !== e.col || beat_write !== e.wr || beat_bank !== e.bank || wr_en !== e.we)
            fail_chk($sformatf("R%0d", e.req), "beat {wr,bank,we,col}",
                     {beat_write, beat_bank, wr_en, beat_col}, {e.wr, e.bank, e.we, e.col});
        end
      end
      while (rd_q.size() > 0 && rd_q[0].cyc < cyc) begin
        checks++; fail_chk($sformatf("R%0d", rd_q[0].req), "missing rd_valid (R7)", 0, 1);
        void'(rd_q.pop_front());
      end
      if (rd_valid) begin
        checks++;
        if (rd_q.size() == 0 || rd_q[0].cyc != cyc) fail_chk("R7", "unexpected rd_valid", 1, 0);
        else begin
          rdx_t r;
          r = rd_q.pop_front();
          if (rd_oe !== r.oe) fail_chk($sformatf("R%0d R8", r.req), "rd_oe", rd_oe, r.oe);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (beat_valid !== 0 || rd_valid !== 0 || mode_err !== 0 || wr_en !== 0)
      fail_chk("R1", "reset outputs", {beat_valid, rd_valid, mode_err, wr_en}, 0);
    step();
    // R1: reset setting CL2 seq BL4; R3 sequential wrap
    col_cmd(0, 9'h0A6, 0, 4, 0, 3); repeat (8) step();
    // R4: interleave BL8 CL3
    set_mode(12'h03B, 1);
    col_cmd(0, 9'h0D5, 1, 8, 0, 4); repeat (12) step();
    // R9: write CL1 BL4 with DQM on beat 1
    set_mode(12'h012, 1);
    dqm_plan[cyc + 1] = 1;
    col_cmd(1, 9'h013, 1, 4, 0, 9); repeat (6) step();
    // R8: read CL2 BL4, DQM in cycle c+1 masks data of beat 1
    set_mode(12'h022, 1);
    dqm_plan[cyc + 1] = 1;
    col_cmd(0, 9'h040, 0, 4, 0, 8); repeat (8) step();
    // R2: illegal words keep CL2 seq BL4
    set_mode(12'h024, 2); set_mode(12'h042, 2); set_mode(12'h00A, 2);
    set_mode(12'h03F, 2); set_mode(12'h822, 2);
    col_cmd(0, 9'h1F3, 1, 4, 0, 2); repeat (8) step();
    // R6: burst length 1
    set_mode(12'h020, 1);
    col_cmd(1, 9'h077, 0, 1, 0, 6); repeat (4) step();
    // R5 + R10: full page CL1, wrap past 511, stop after 5 beats
    set_mode(12'h017, 1);
    col_cmd(0, 9'h1FE, 0, 5, 0, 5); repeat (4) step();
    stop = 1; step(); stop = 0; repeat (6) step();
    // R10: stop a CL2 BL8 read after 3 beats
    set_mode(12'h023, 1);
    col_cmd(0, 9'h100, 1, 3, 0, 10); repeat (2) step();
    stop = 1; step(); stop = 0; repeat (6) step();
    // R11: read interrupted by write after 2 beats
    col_cmd(0, 9'h020, 0, 2, 0, 11); step();
    col_cmd(1, 9'h0F0, 1, 8, 0, 11); repeat (12) step();
    // R12: precharge on beat 2 of read, CL1/CL2/CL3
    set_mode(12'h013, 1);
    col_cmd(0, 9'h010, 0, 3, 1, 12); step();
    precharge = 1; step(); precharge = 0; repeat (6) step();
    set_mode(12'h023, 1);
    col_cmd(0, 9'h018, 1, 3, 1, 12); step();
    precharge = 1; step(); precharge = 0; repeat (6) step();
    set_mode(12'h033, 1);
    col_cmd(0, 9'h028, 0, 3, 1, 12); step();
    precharge = 1; step(); precharge = 0; repeat (6) step();
    // R12: precharge masks the write beat of its own cycle
    col_cmd(1, 9'h030, 1, 2, 1, 12);
    precharge = 1; step(); precharge = 0; repeat (6) step();
    checks++;
    if (beat_q.size() != 0 || rd_q.size() != 0)
      fail_chk("R6", "leftover expectations", beat_q.size() + rd_q.size(), 0);
    finish_run();
  end
endmodule